// File: doc/BRIEF.md
# Quasi-Bidirectional Port Drive Controller

This block sits between a processor core and the pad ring of one 8-bit general-purpose port. It holds the port's output latch and, for every pin, decides which of three pad drivers is switched on: a strong pulldown, a short-lived strong pullup, or a weak sustaining pullup. A pin whose drive value is 1 is held high only weakly, so an external circuit can pull it low and the pin can serve as an input.

When a pin's drive value goes from 0 to 1, the block turns on the strong pullup for a fixed number of clocks so the line rises quickly. It then hands over to the weak keeper. Each pin times its own boost with a separate counter.

The core writes the whole latch in one byte write and reads back both the latch and the pin levels. The pin levels pass through a two-flop synchronizer first. An alternate peripheral function can take over the drive value of any pin through a select bit for that pin. While it does, the latch keeps its contents but has no effect on that pin.

Top module: `qbd_port_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, every `port_latch` bit is 1, every `weak_up_en` bit is 1, and every `pull_dn_en` and `boost_up_en` bit is 0.
- R2: A clock edge with `wr_en` high loads `wr_data` into `port_latch`. A clock edge with `wr_en` low leaves `port_latch` unchanged.
- R3: After reset, exactly one of `pull_dn_en[i]`, `boost_up_en[i]` and `weak_up_en[i]` is 1 for each pin i, in every cycle.
- R4: The drive value of pin i is `alt_val[i]` when `alt_sel[i]` is 1, and the latch bit otherwise. From the clock edge where the drive value becomes 0, `pull_dn_en[i]` is 1, and it stays 1 for as long as the drive value stays 0.
- R5: At the clock edge where the drive value of pin i changes from 0 to 1, `boost_up_en[i]` turns on. It stays on for exactly 2 cycles, and `weak_up_en[i]` is 0 during that time. After that, only `weak_up_en[i]` is on.
- R6: Writing 1 to a pin whose drive value is already 1 starts no boost. `weak_up_en` stays 1 for that pin.
- R7: With `alt_sel[i]` = 1, writes to latch bit i still update `port_latch[i]` but do not change that pin's drivers. A 0-to-1 change of `alt_val[i]` starts a boost, in the same way as described in R5.
- R8: `pin_sync` equals the value of `pin_in` sampled two clock edges earlier.
- R9: If the drive value returns to 0 while a boost is running, the boost ends at that edge and `pull_dn_en` turns on.
- R10: Each pin times its boost on its own. Boosts that start on different pins at different edges each last their full 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe for the latch |
| wr_data | input | 8 | Value written into the latch |
| alt_sel | input | 8 | Per-pin hand-over to the alternate function |
| alt_val | input | 8 | Drive value supplied by the alternate function |
| pin_in | input | 8 | Raw pad input levels |
| port_latch | output | 8 | Current latch contents |
| pull_dn_en | output | 8 | Strong pulldown enable per pin |
| boost_up_en | output | 8 | Momentary strong pullup enable per pin |
| weak_up_en | output | 8 | Weak sustaining pullup enable per pin |
| pin_sync | output | 8 | Synchronized pin levels |

## Verification
The latch and all three driver enables are registered. They change at the first clock edge after the write or the alternate-input change that causes them. The boost stays on through that edge and the next one and is gone after the third. `pin_sync` lags `pin_in` by two edges.

The bench drives inputs on falling edges and updates a cycle model on rising edges. It compares every output on the following falling edge, so each result is checked in the exact cycle it is due. The directed cases read the boost pattern one falling edge at a time to confirm its two-cycle length.

// File: rtl/qbd_pkg.sv
package qbd_pkg;
  // per-pin pad driver enables
  typedef struct packed {
    logic pull_dn;
    logic boost_up;
    logic weak_up;
  } pad_drive_t;

  localparam pad_drive_t DRIVE_IDLE = '{pull_dn: 1'b0, boost_up: 1'b0, weak_up: 1'b1};
endpackage

// File: rtl/qbd_sync.sv
module qbd_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) stage_q[0] <= d;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) stage_q[s] <= stage_q[s-1];
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/qbd_pin_cell.sv
module qbd_pin_cell
  import qbd_pkg::*;
#(
  parameter int BOOST_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       drv_next,
  output pad_drive_t drive
);
  localparam int CW = $clog2(BOOST_CYCLES + 1);

  logic          drv_q;
  logic [CW-1:0] cnt_q, cnt_next;
  pad_drive_t    drive_q;

  // boost counter: loaded on a rising drive value, cleared on a falling one
  always_comb begin
    if (!drv_next)               cnt_next = '0;
    else if (!drv_q)             cnt_next = CW'(BOOST_CYCLES);
    else if (cnt_q != '0)        cnt_next = cnt_q - 1'b1;
    else                         cnt_next = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_q   <= 1'b1;
      cnt_q   <= '0;
      drive_q <= DRIVE_IDLE;
    end else begin
      drv_q            <= drv_next;
      cnt_q            <= cnt_next;
      drive_q.pull_dn  <= !drv_next;
      drive_q.boost_up <= (cnt_next != '0);
      drive_q.weak_up  <= drv_next && (cnt_next == '0);
    end
  end

  assign drive = drive_q;
endmodule

// File: rtl/qbd_port_ctrl.sv
module qbd_port_ctrl
  import qbd_pkg::*;
#(
  parameter int WIDTH        = 8,
  parameter int BOOST_CYCLES = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] alt_sel,
  input  logic [WIDTH-1:0] alt_val,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] port_latch,
  output logic [WIDTH-1:0] pull_dn_en,
  output logic [WIDTH-1:0] boost_up_en,
  output logic [WIDTH-1:0] weak_up_en,
  output logic [WIDTH-1:0] pin_sync
);
  logic [WIDTH-1:0] latch_q, latch_next, drv_next;

  assign latch_next = wr_en ? wr_data : latch_q;
  assign drv_next   = (alt_sel & alt_val) | (~alt_sel & latch_next);

  always_ff @(posedge clk) begin
    if (rst) latch_q <= '1;
    else     latch_q <= latch_next;
  end

  assign port_latch = latch_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    pad_drive_t drv;
    qbd_pin_cell #(.BOOST_CYCLES(BOOST_CYCLES)) cell_i (
      .clk      (clk),
      .rst      (rst),
      .drv_next (drv_next[i]),
      .drive    (drv)
    );
    assign pull_dn_en[i]  = drv.pull_dn;
    assign boost_up_en[i] = drv.boost_up;
    assign weak_up_en[i]  = drv.weak_up;
  end

  qbd_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .d   (pin_in),
    .q   (pin_sync)
  );
endmodule

// File: rtl/qbd_port_ctrl_chk.sv
module qbd_port_ctrl_chk #(
  parameter int WIDTH        = 8,
  parameter int BOOST_CYCLES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [WIDTH-1:0] wr_data,
  input logic [WIDTH-1:0] alt_sel,
  input logic [WIDTH-1:0] alt_val,
  input logic [WIDTH-1:0] pin_in,
  input logic [WIDTH-1:0] port_latch,
  input logic [WIDTH-1:0] pull_dn_en,
  input logic [WIDTH-1:0] boost_up_en,
  input logic [WIDTH-1:0] weak_up_en,
  input logic [WIDTH-1:0] pin_sync
);
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                   since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (port_latch == '1 && weak_up_en == '1 && pull_dn_en == '0 && boost_up_en == '0));

  a_r2_latch_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(port_latch));

  a_r8_sync_delay: assert property (@(posedge clk) disable iff (rst)
    since_rst == 2'd3 |-> pin_sync == $past(pin_in, 2));

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    a_r3_one_driver: assert property (@(posedge clk) disable iff (rst)
      $countones({pull_dn_en[i], boost_up_en[i], weak_up_en[i]}) == 1);

    a_r4_write_zero: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !alt_sel[i] && !wr_data[i]) |=> pull_dn_en[i]);

    a_r5_boost_start: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !alt_sel[i] && wr_data[i] && pull_dn_en[i]) |=> boost_up_en[i]);

    a_r6_no_reboost: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !alt_sel[i] && wr_data[i] && weak_up_en[i]) |=> (weak_up_en[i] && !boost_up_en[i]));

    a_r7_alt_low: assert property (@(posedge clk) disable iff (rst)
      (alt_sel[i] && !alt_val[i]) |=> pull_dn_en[i]);

    if (BOOST_CYCLES == 2) begin : g_len
      a_r5_boost_len: assert property (@(posedge clk) disable iff (rst)
        (boost_up_en[i] && $past(boost_up_en[i])) |=> !boost_up_en[i]);
    end
  end
endmodule

bind qbd_port_ctrl qbd_port_ctrl_chk #(.WIDTH(WIDTH), .BOOST_CYCLES(BOOST_CYCLES)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .alt_sel     (alt_sel),
  .alt_val     (alt_val),
  .pin_in      (pin_in),
  .port_latch  (port_latch),
  .pull_dn_en  (pull_dn_en),
  .boost_up_en (boost_up_en),
  .weak_up_en  (weak_up_en),
  .pin_sync    (pin_sync)
);

// File: tb/qbd_port_ctrl_tb.sv
module qbd_port_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;
  localparam int BOOST      = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0, alt_sel = '0, alt_val = '0, pin_in = '0;
  logic [W-1:0] port_latch, pull_dn_en, boost_up_en, weak_up_en, pin_sync;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qbd_port_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .alt_sel(alt_sel), .alt_val(alt_val), .pin_in(pin_in),
    .port_latch(port_latch), .pull_dn_en(pull_dn_en),
    .boost_up_en(boost_up_en), .weak_up_en(weak_up_en), .pin_sync(pin_sync)
  );

  // cycle model built from the requirements
  logic [W-1:0] m_latch = '1, m_drv = '1, m_s1 = '0, m_s2 = '0;
  int           m_cnt [W];
  logic         m_live = 1'b0;

  always @(posedge clk) begin
    logic [W-1:0] ln, d;
    ln = wr_en ? wr_data : m_latch;
    d  = (alt_sel & alt_val) | (~alt_sel & ln);
    if (rst) begin
      m_latch <= '1; m_drv <= '1; m_live <= 1'b0;
      for (int i = 0; i < W; i++) m_cnt[i] <= 0;
    end else begin
      m_latch <= ln; m_drv <= d; m_live <= 1'b1;
      for (int i = 0; i < W; i++) begin
        if (!d[i])           m_cnt[i] <= 0;
        else if (!m_drv[i])  m_cnt[i] <= BOOST;
        else if (m_cnt[i] > 0) m_cnt[i] <= m_cnt[i] - 1;
      end
    end
    m_s1 <= pin_in; m_s2 <= m_s1;
  end

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (m_live && !done) begin
      logic [W-1:0] eb, ew;
      for (int i = 0; i < W; i++) begin
        eb[i] = m_cnt[i] != 0;
        ew[i] = m_drv[i] && m_cnt[i] == 0;
      end
      check("R2", port_latch, m_latch);
      check("R4", pull_dn_en, ~m_drv);
      check("R5", boost_up_en, eb);
      check("R5", weak_up_en, ew);
      check("R3", pull_dn_en ^ boost_up_en ^ weak_up_en, '1);
      check("R3", (pull_dn_en & boost_up_en) | (pull_dn_en & weak_up_en) | (boost_up_en & weak_up_en), '0);
      check("R8", pin_sync, m_s2);
    end
  end

  task automatic wr(logic [W-1:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    // R1: during reset
    check("R1", port_latch, '1);
    check("R1", weak_up_en, '1);
    check("R1", pull_dn_en | boost_up_en, '0);
    rst = 1'b0;
    idle(1);
    check("R1", weak_up_en, '1);

    // R6: writing ones over ones
    wr('1);
    check("R6", boost_up_en, '0);
    check("R6", weak_up_en, '1);

    // R10: staggered boosts on two pins
    wr('0); idle(1);
    wr(8'h01);
    check("R10", boost_up_en, 8'h01);
    wr(8'h03);
    check("R10", boost_up_en, 8'h03);
    idle(1);
    check("R10", boost_up_en, 8'h02);
    idle(1);
    check("R10", boost_up_en, 8'h00);
    check("R10", weak_up_en, 8'h03);

    // R9: drive falls during a boost
    wr('0); idle(1);
    wr('1);
    check("R9", boost_up_en, '1);
    wr('0);
    check("R9", boost_up_en, '0);
    check("R9", pull_dn_en, '1);

    // R7: alternate function owns the pins
    alt_sel = '1; alt_val = '1;
    idle(1);
    check("R7", boost_up_en, '1);
    check("R7", port_latch, '0);
    wr(8'hA5);
    check("R7", port_latch, 8'hA5);
    check("R7", pull_dn_en, '0);
    alt_val = '0;
    idle(1);
    check("R7", pull_dn_en, '1);
    alt_sel = '0; alt_val = '0;
    idle(3);

    // sweep of every latch transition pair v -> ~v -> v, pins and alt varied
    for (int v = 0; v < 256; v++) begin
      pin_in = W'(v * 37 + 11);
      wr(W'(v));
      idle(1);
      pin_in = W'(v ^ 8'h5A);
      wr(~W'(v));
      idle(3);
      alt_sel = W'(v * 3); alt_val = W'(v * 7);
      idle(2);
      alt_sel = '0;
      wr(W'(v));
      idle(3);
    end

    // R2: no write leaves latch alone
    wr(8'h3C); idle(4);
    check("R2", port_latch, 8'h3C);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule